// File: doc/BRIEF.md
# Privileged stack pointer fetcher

This unit looks up the inner-level stack of the current task. Given a privilege level from 0 to 2, it reads the stack segment selector and the stack pointer for that level out of the task state segment that the task register describes. The caller sends a one-cycle request together with the level and the cached task-register fields: base, limit, valid flag, type code and selector. The unit then fetches the two fields through a simple request/acknowledge memory port and ends with exactly one of three one-cycle pulses.

A descriptor type of 32-bit available or busy selects the wide layout. In that layout each level has an 8-byte slot: a doubleword pointer followed by a word selector. A type of 16-bit available or busy selects the narrow layout. In that layout each level has a 4-byte slot: a word pointer, which is zero-extended, followed by a word selector. Before any memory access the slot is checked against the segment limit. A slot that does not fit raises an invalid-segment fault. A cache marked invalid, or any other type code, is reported as a fatal inconsistency.

Top module: `priv_stack_fetch`

## Requirements
- R1: With type code 9 or 11 (32-bit, available or busy), the first read is a doubleword (`mem_wide`=1) at base + 8·level + 4 and its value becomes `sp`. The second read is a word (`mem_wide`=0) at base + 8·level + 8, and its low 16 bits become `ss_sel`.
- R2: With type code 1 or 3 (16-bit, available or busy), the first read is a word at base + 4·level + 2, and `sp` takes its low 16 bits with the upper 16 bits zero. The second read is a word at base + 4·level + 4, and it supplies `ss_sel`.
- R3: In the 32-bit layout, if (8·level + 4) + 7 exceeds the limit, the unit pulses `fault` with `fault_code` equal to the task selector with bits 1:0 cleared, and it issues no read. A limit equal to that sum passes.
- R4: In the 16-bit layout, if (4·level + 2) + 3 exceeds the limit, the unit pulses `fault` with the same code and issues no read. A limit equal to that sum passes.
- R5: When `tr_valid` is low, or the type code is anything other than 1, 3, 9 or 11, the unit pulses `fatal` one cycle after the request and issues no read and no fault.
- R6: `done` is a one-cycle pulse in the cycle after the acknowledge of the second read. Only one of `done`, `fault` and `fatal` is ever high at a time.
- R7: Once raised, `mem_req` stays high with a stable address and width until `mem_ack` is seen.
- R8: After reset, `done`, `fault`, `fatal` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle lookup request, taken when idle |
| level | input | 2 | Privilege level whose stack is wanted |
| tr_base | input | ADDR_W | Task segment base address |
| tr_limit | input | 32 | Task segment limit in bytes |
| tr_valid | input | 1 | Task-register cache valid |
| tr_type | input | 4 | Task segment descriptor type code |
| tr_sel | input | 16 | Task-register selector |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Read byte address |
| mem_wide | output | 1 | 1 = doubleword read, 0 = word read |
| mem_ack | input | 1 | Read complete, data valid on `mem_rdata` |
| mem_rdata | input | 32 | Read data, little-endian from `mem_addr` |
| ss_sel | output | 16 | Fetched stack segment selector |
| sp | output | 32 | Fetched stack pointer |
| done | output | 1 | Lookup finished pulse |
| fault | output | 1 | Limit violation pulse |
| fault_code | output | 16 | Error code for `fault` |
| fatal | output | 1 | Invalid cache or unknown type pulse |

## Verification
The bench builds the unit with the default 32-bit address width. This width lets a task segment sit high in the address space, so it can show that the slot address is a plain sum of base and offset. The vector set covers every legal type code and each level in both layouts. It also puts limits exactly on the boundary and one byte below it, so each limit comparison is tested on both sides. The memory model acknowledges one cycle after each request. That delay shows the hold behaviour of the read port, and it lets the bench log each read's address and width so they can be compared with the expected slot layout.

// File: rtl/priv_stack_fetch.sv
module priv_stack_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] tr_base,
  input  logic [31:0]       tr_limit,
  input  logic              tr_valid,
  input  logic [3:0]        tr_type,
  input  logic [15:0]       tr_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [15:0]       ss_sel,
  output logic [31:0]       sp,
  output logic              done,
  output logic              fault,
  output logic [15:0]       fault_code,
  output logic              fatal
);

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_SEL} state_t;
  state_t state;

  logic              wide_q;
  logic [4:0]        off_q;
  logic [ADDR_W-1:0] base_q;

  logic       is_wide, is_narrow, known;
  logic [4:0] off;
  logic [5:0] last_byte;
  logic       over_limit;

  assign is_wide    = (tr_type == 4'd9) || (tr_type == 4'd11);
  assign is_narrow  = (tr_type == 4'd1) || (tr_type == 4'd3);
  assign known      = tr_valid && (is_wide || is_narrow);
  assign off        = is_wide ? {level, 3'b100} : {1'b0, level, 2'b10};
  assign last_byte  = {1'b0, off} + (is_wide ? 6'd7 : 6'd3);
  assign over_limit = {26'd0, last_byte} > tr_limit;

  assign mem_req  = (state != S_IDLE);
  assign mem_wide = (state == S_PTR) && wide_q;
  assign mem_addr = base_q + ADDR_W'(off_q)
                  + ((state == S_SEL) ? (wide_q ? ADDR_W'(4) : ADDR_W'(2)) : ADDR_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wide_q     <= 1'b0;
      off_q      <= '0;
      base_q     <= '0;
      ss_sel     <= '0;
      sp         <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      fatal      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      fatal <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          if (!known) begin
            fatal <= 1'b1;
          end else if (over_limit) begin
            fault      <= 1'b1;
            fault_code <= {tr_sel[15:2], 2'b00};
          end else begin
            wide_q <= is_wide;
            off_q  <= off;
            base_q <= tr_base;
            state  <= S_PTR;
          end
        end
        S_PTR: if (mem_ack) begin
          sp    <= wide_q ? mem_rdata : {16'd0, mem_rdata[15:0]};
          state <= S_SEL;
        end
        S_SEL: if (mem_ack) begin
          ss_sel <= mem_rdata[15:0];
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, fault, fatal}) <= 1);

  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_wide && state == S_SEL) |=> done);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wide)));

  // R5
  fatal_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req && !known) |=> (fatal && !mem_req && !fault));

  // R3
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code[1:0] == 2'b00 && !mem_req));

endmodule

// File: tb/tb_priv_stack_fetch.sv
module tb_priv_stack_fetch;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, req, tr_valid, mem_ack, mem_req, mem_wide, done, fault, fatal;
  logic [1:0] level;
  logic [31:0] tr_base, tr_limit, mem_addr, mem_rdata, sp;
  logic [3:0] tr_type;
  logic [15:0] tr_sel, ss_sel, fault_code;

  priv_stack_fetch #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .level(level), .tr_base(tr_base),
    .tr_limit(tr_limit), .tr_valid(tr_valid), .tr_type(tr_type), .tr_sel(tr_sel),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ss_sel(ss_sel), .sp(sp), .done(done), .fault(fault),
    .fault_code(fault_code), .fatal(fatal));

  function automatic logic [7:0] byte_at(logic [31:0] a);
    return 8'((a * 32'd7) + 32'd3);
  endfunction
  function automatic logic [31:0] dword_at(logic [31:0] a);
    return {byte_at(a + 3), byte_at(a + 2), byte_at(a + 1), byte_at(a)};
  endfunction
  function automatic logic [15:0] word_at(logic [31:0] a);
    return {byte_at(a + 1), byte_at(a)};
  endfunction

  int n_reads;
  logic [31:0] rd_addr [2];
  logic        rd_wide [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem_wide ? dword_at(mem_addr) : {16'd0, word_at(mem_addr)};
        if (n_reads < 2) begin
          rd_addr[n_reads] <= mem_addr;
          rd_wide[n_reads] <= mem_wide;
        end
        n_reads <= n_reads + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        vld;
    logic [3:0]  typ;
    logic [1:0]  lvl;
    logic [31:0] lim;
    logic [31:0] base;
    logic [15:0] sel;
    logic [1:0]  res;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd9,  2'd0, 32'h67, 32'h1000, 16'h0028, 2'd0},
    '{1'b1, 4'd11, 2'd2, 32'h67, 32'h2000, 16'h0030, 2'd0},
    '{1'b1, 4'd9,  2'd2, 32'h1B, 32'h3000, 16'h0033, 2'd0},
    '{1'b1, 4'd9,  2'd2, 32'h1A, 32'h3000, 16'h0033, 2'd1},
    '{1'b1, 4'd1,  2'd0, 32'h2B, 32'h4000, 16'h0041, 2'd0},
    '{1'b1, 4'd3,  2'd2, 32'h0D, 32'h5000, 16'h0052, 2'd0},
    '{1'b1, 4'd3,  2'd2, 32'h0C, 32'h5000, 16'h0057, 2'd1},
    '{1'b1, 4'd1,  2'd1, 32'h2B, 32'h6000, 16'h0060, 2'd0},
    '{1'b1, 4'd5,  2'd0, 32'h67, 32'h7000, 16'h0070, 2'd2},
    '{1'b0, 4'd9,  2'd0, 32'h67, 32'h8000, 16'h0080, 2'd2},
    '{1'b1, 4'd11, 2'd1, 32'hFFFF, 32'hFFFF0000, 16'h0099, 2'd0}
  };

  initial begin
    rst_n = 0; req = 0; level = 0; tr_base = 0; tr_limit = 0;
    tr_valid = 0; tr_type = 0; tr_sel = 0; n_reads = 0;
    repeat (3) @(negedge clk);
    check(!done && !fault && !fatal && !mem_req, "R8 reset", {done, fault, fatal, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !fault && !fatal && !mem_req, "R8 after reset", {done, fault, fatal, mem_req}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic w;
      logic [31:0] off, pa, sa;
      logic [1:0] got;
      int waited;
      v = VECS[i];
      w = (v.typ == 4'd9) || (v.typ == 4'd11);
      off = w ? (32'd8 * v.lvl + 32'd4) : (32'd4 * v.lvl + 32'd2);
      pa = v.base + off;
      sa = pa + (w ? 32'd4 : 32'd2);
      n_reads = 0;
      tr_valid = v.vld; tr_type = v.typ; level = v.lvl; tr_limit = v.lim;
      tr_base = v.base; tr_sel = v.sel; req = 1;
      @(negedge clk);
      req = 0;
      got = 2'd3;
      waited = 0;
      while (!(done || fault || fatal) && waited < 50) begin
        @(negedge clk);
        waited++;
      end
      if (done) got = 2'd0; else if (fault) got = 2'd1; else if (fatal) got = 2'd2;
      check(got == v.res, $sformatf("R6 vector %0d outcome", i), got, v.res);
      if (v.res == 2'd0) begin
        check(n_reads == 2, $sformatf("R1/R2 vector %0d read count", i), n_reads, 2);
        check(rd_addr[0] == pa && rd_wide[0] == w, $sformatf("%s vector %0d ptr addr", w ? "R1" : "R2", i),
              rd_addr[0], pa);
        check(rd_addr[1] == sa && rd_wide[1] == 1'b0, $sformatf("%s vector %0d sel addr", w ? "R1" : "R2", i),
              rd_addr[1], sa);
        check(sp == (w ? dword_at(pa) : {16'd0, word_at(pa)}), $sformatf("R1 R2 vector %0d sp", i),
              sp, w ? dword_at(pa) : {16'd0, word_at(pa)});
        check(ss_sel == word_at(sa), $sformatf("R1 R2 vector %0d ss_sel", i), ss_sel, word_at(sa));
      end else begin
        check(n_reads == 0, $sformatf("R3 R4 R5 vector %0d no reads", i), n_reads, 0);
        if (v.res == 2'd1)
          check(fault_code == {v.sel[15:2], 2'b00}, $sformatf("%s vector %0d code", w ? "R3" : "R4", i),
                fault_code, {v.sel[15:2], 2'b00});
      end
      @(negedge clk);
      check(!done && !fault && !fatal, $sformatf("R6 vector %0d single pulse", i), {done, fault, fatal}, 0);
      repeat (2) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule